// File: doc/BRIEF.md
# Sine Test Pattern Serializer

This block produces an endless train of digital sine samples for a serial audio DAC that is under distortion test. A wrapping address counter walks a sine table that is computed at elaboration and held in an inferred ROM. Each table entry passes through a level scaler that sets full scale, -20 dB or -60 dB, or mutes the output. The scaled 16-bit two's complement word is then shifted out MSB first, framed by a word clock and closed by a latch-enable pulse.

A one-cycle sample tick, normally at four times 44.1 kHz (176.4 kHz), requests the next word. The bit clock runs freely from a divider whose ratio is derived from the system clock frequency, the sample rate and the number of bit-clock periods allowed per sample. With the default table of 178 entries the tone lands at about 991 Hz.

Top module: `sine_pattern_ser`

## Requirements
- R1: While reset is high, and on the first cycle after it, serial data, bit clock, word clock and latch enable are all low.
- R2: With level code 0, the k-th word sent after reset (k from 0) equals round(AMPL * sin(2*pi*k/DEPTH)), rounded half away from zero, in two's complement and sent MSB first.
- R3: After table entry DEPTH-1 the next word uses entry 0, so the waveform repeats without a gap.
- R4: The word clock is high for exactly W rising bit-clock edges, one for each data bit. It falls after the last bit. Data and word clock change only on falling bit-clock edges.
- R5: Latch enable is a single system-clock pulse, high only in the cycle where the bit clock rises for the first time after the word clock falls. It occurs once per word.
- R6: The level code is taken when a word starts. Code 0 multiplies by 65536/65536, code 1 by 6554/65536 (-20 dB) and code 2 by 66/65536 (-60 dB). The product is rounded as floor((s*c + 32768) / 65536).
- R7: Level code 3 sends an all-zero word, and the table still advances by one entry.
- R8: A tick that arrives while a word is waiting to start or is being sent is dropped. No extra word is sent and the table does not skip an entry.
- R9: The bit clock runs freely with a period of 2*HALF_DIV system clocks, where HALF_DIV = floor(CLK_HZ / (2*SAMPLE_HZ*BITS_PER_SAMPLE)).
- R10: With no tick, the word clock stays low and no latch pulse occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | One-cycle request for the next sample word |
| level_sel | input | 2 | Output level: 0 full, 1 -20 dB, 2 -60 dB, 3 mute |
| ser_data | output | 1 | Serial sample data, MSB first |
| ser_bclk | output | 1 | Free-running bit clock |
| ser_wclk | output | 1 | Word clock, high while data bits are sent |
| latch_en | output | 1 | Pulse at the rising bit-clock edge that transfers the word |

## Verification
The bench acts as the receiving DAC. It shifts data on rising bit-clock edges and takes the word at the first rising edge after the word clock falls. Every received word is compared against a sine computed in floating point and scaled by the selected level, across two full table periods for each of the four level codes. This sweep catches a table that wraps early or late, which shows as a phase jump at entry 0, and a scaler that truncates instead of rounding, which is off by one on the -20 dB codes. It also catches an LSB-first or off-by-one shifter, which corrupts every word, and a latch pulse placed on the wrong edge. Back-to-back and mid-frame ticks test the request filter: a design that queued them would send an extra word and shift every later sample by one table entry.

// File: rtl/sine_pattern_pkg.sv
package sine_pattern_pkg;

  localparam int FRAC_BITS = 16;
  localparam longint PI_Q30 = 64'sd3373259426;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SHIFT = 2'd1,
    FR_TAIL  = 2'd2
  } frame_state_e;

  // Q16 level coefficients; the index is the level select code.
  function automatic int level_coef(input logic [1:0] sel);
    case (sel)
      2'd0:    return 65536;
      2'd1:    return 6554;
      2'd2:    return 66;
      default: return 0;
    endcase
  endfunction

  // Fixed-point sine on a quarter wave, Taylor series in Q30.
  function automatic int sine_code(input int idx, input int depth, input int ampl);
    longint ang;
    longint x2;
    longint term;
    longint sum;
    longint mag;
    logic   neg;
    ang = (2 * PI_Q30 * longint'(idx)) / longint'(depth);
    neg = 1'b0;
    if (ang >= PI_Q30) begin
      ang = ang - PI_Q30;
      neg = 1'b1;
    end
    if (2 * ang > PI_Q30) ang = PI_Q30 - ang;
    x2   = (ang * ang) >>> 30;
    term = ang;
    sum  = ang;
    for (int k = 1; k <= 7; k++) begin
      term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
      sum  = sum + term;
    end
    mag = (sum * longint'(ampl) + (64'sd1 <<< 29)) >>> 30;
    return neg ? -int'(mag) : int'(mag);
  endfunction

endpackage

// File: rtl/sine_rom.sv
module sine_rom
  import sine_pattern_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 178,
  parameter int AMPL  = 32767,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic [AW-1:0]       addr,
  output logic signed [W-1:0] data_o
);

  logic signed [W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = W'(sine_code(i, DEPTH, AMPL));
    end
  end

  // Registered read so the table maps onto block RAM.
  always_ff @(posedge clk) begin
    data_o <= mem[addr];
  end

endmodule

// File: rtl/level_scaler.sv
module level_scaler
  import sine_pattern_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] din,
  input  logic [1:0]          sel,
  output logic signed [W-1:0] dout
);

  localparam int CW = FRAC_BITS + 2;
  localparam int PW = W + CW;

  logic signed [CW-1:0] coef;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] biased;

  always_comb begin
    coef   = CW'(level_coef(sel));
    prod   = PW'(din) * PW'(coef);
    biased = prod + (PW'(1) <<< (FRAC_BITS - 1));
    dout   = W'(biased >>> FRAC_BITS);
  end

endmodule

// File: rtl/bit_clock_gen.sv
module bit_clock_gen #(
  parameter int HALF_DIV = 4,
  localparam int CW      = $clog2(HALF_DIV) + 1
) (
  input  logic clk,
  input  logic rst,
  output logic bclk_o,
  output logic rise_o,
  output logic fall_o
);

  logic [CW-1:0] cnt_q;
  logic          bclk_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(HALF_DIV - 1));
  assign rise_o = wrap & ~bclk_q;
  assign fall_o = wrap & bclk_q;
  assign bclk_o = bclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/word_framer.sv
module word_framer
  import sine_pattern_pkg::*;
#(
  parameter int W = 16,
  localparam int SW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic [W-1:0] word_i,
  output logic         load_o,
  output logic         sdata_o,
  output logic         wclk_o,
  output logic         latch_o
);

  frame_state_e  state_q;
  logic          pending_q;
  logic [W-1:0]  shift_q;
  logic [SW-1:0] bit_cnt_q;
  logic          sdata_q;
  logic          wclk_q;
  logic          latch_q;

  assign load_o  = fall_i && (state_q == FR_IDLE) && pending_q;
  assign sdata_o = sdata_q;
  assign wclk_o  = wclk_q;
  assign latch_o = latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= FR_IDLE;
      pending_q <= 1'b0;
      shift_q   <= '0;
      bit_cnt_q <= '0;
      sdata_q   <= 1'b0;
      wclk_q    <= 1'b0;
      latch_q   <= 1'b0;
    end else begin
      latch_q <= 1'b0;
      if (tick_i && !pending_q && (state_q == FR_IDLE)) begin
        pending_q <= 1'b1;
      end
      if (load_o) begin
        pending_q <= 1'b0;
        shift_q   <= word_i;
        sdata_q   <= word_i[W-1];
        wclk_q    <= 1'b1;
        bit_cnt_q <= '0;
        state_q   <= FR_SHIFT;
      end else if (fall_i && (state_q == FR_SHIFT)) begin
        if (bit_cnt_q == SW'(W - 1)) begin
          wclk_q  <= 1'b0;
          sdata_q <= 1'b0;
          state_q <= FR_TAIL;
        end else begin
          shift_q   <= {shift_q[W-2:0], 1'b0};
          sdata_q   <= shift_q[W-2];
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
      end else if (fall_i && (state_q == FR_TAIL)) begin
        state_q <= FR_IDLE;
      end
      if (rise_i && (state_q == FR_TAIL)) begin
        latch_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sine_pattern_ser.sv
module sine_pattern_ser
  import sine_pattern_pkg::*;
#(
  parameter int W               = 16,
  parameter int DEPTH           = 178,
  parameter int AMPL            = 32767,
  parameter int CLK_HZ          = 50_000_000,
  parameter int SAMPLE_HZ       = 176_400,
  parameter int BITS_PER_SAMPLE = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sample_tick,
  input  logic [1:0] level_sel,
  output logic       ser_data,
  output logic       ser_bclk,
  output logic       ser_wclk,
  output logic       latch_en
);

  localparam int AW       = $clog2(DEPTH);
  localparam int HALF_DIV = CLK_HZ / (2 * SAMPLE_HZ * BITS_PER_SAMPLE);

  logic [AW-1:0]       addr_q;
  logic signed [W-1:0] rom_word;
  logic signed [W-1:0] scaled_word;
  logic                bit_rise;
  logic                bit_fall;
  logic                load;

  sine_rom #(.W(W), .DEPTH(DEPTH), .AMPL(AMPL)) u_rom (
    .clk    (clk),
    .addr   (addr_q),
    .data_o (rom_word)
  );

  level_scaler #(.W(W)) u_scale (
    .din  (rom_word),
    .sel  (level_sel),
    .dout (scaled_word)
  );

  bit_clock_gen #(.HALF_DIV(HALF_DIV)) u_bclk (
    .clk    (clk),
    .rst    (rst),
    .bclk_o (ser_bclk),
    .rise_o (bit_rise),
    .fall_o (bit_fall)
  );

  word_framer #(.W(W)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (sample_tick),
    .rise_i  (bit_rise),
    .fall_i  (bit_fall),
    .word_i  (scaled_word),
    .load_o  (load),
    .sdata_o (ser_data),
    .wclk_o  (ser_wclk),
    .latch_o (latch_en)
  );

  // Table address steps once per word and wraps at the last entry.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= (addr_q == AW'(DEPTH - 1)) ? '0 : addr_q + 1'b1;
    end
  end

endmodule

// File: rtl/sine_pattern_ser_chk.sv
module sine_pattern_ser_chk #(
  parameter int CLK_HZ          = 50_000_000,
  parameter int SAMPLE_HZ       = 176_400,
  parameter int BITS_PER_SAMPLE = 32
) (
  input logic clk,
  input logic rst,
  input logic ser_data,
  input logic ser_bclk,
  input logic ser_wclk,
  input logic latch_en
);

  localparam int HALF_DIV = CLK_HZ / (2 * SAMPLE_HZ * BITS_PER_SAMPLE);

  logic        bclk_d;
  logic        toggled_once;
  logic [31:0] run_len;

  always_ff @(posedge clk) begin
    bclk_d <= ser_bclk;
    if (rst) begin
      run_len      <= '0;
      toggled_once <= 1'b0;
    end else if (ser_bclk != bclk_d) begin
      run_len      <= '0;
      toggled_once <= 1'b1;
    end else begin
      run_len      <= run_len + 1;
    end
  end

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!ser_data && !ser_bclk && !ser_wclk && !latch_en));

  // R4
  a_r4_wclk_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_wclk) |-> $fell(ser_bclk));

  // R4
  a_r4_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_data) |-> $fell(ser_bclk));

  // R5
  a_r5_latch_single: assert property (@(posedge clk) disable iff (rst)
    latch_en |=> !latch_en);

  // R5
  a_r5_latch_on_rise: assert property (@(posedge clk) disable iff (rst)
    latch_en |-> $rose(ser_bclk) && !ser_wclk);

  // R9
  a_r9_bclk_period: assert property (@(posedge clk) disable iff (rst)
    (toggled_once && (ser_bclk != bclk_d)) |-> (run_len == 32'(HALF_DIV - 1)));

endmodule

bind sine_pattern_ser sine_pattern_ser_chk #(
  .CLK_HZ          (CLK_HZ),
  .SAMPLE_HZ       (SAMPLE_HZ),
  .BITS_PER_SAMPLE (BITS_PER_SAMPLE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ser_data (ser_data),
  .ser_bclk (ser_bclk),
  .ser_wclk (ser_wclk),
  .latch_en (latch_en)
);

// File: tb/sine_pattern_ser_test.sv
module sine_pattern_ser_test;

  localparam int W        = 16;
  localparam int DEPTH    = 20;
  localparam int AMPL     = 32767;
  localparam int CLK_HZ   = 50_000_000;
  localparam int SRATE    = 390_625;
  localparam int BPS      = 32;
  localparam int HALF_DIV = CLK_HZ / (2 * SRATE * BPS);
  localparam int GAP      = 128;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample_tick = 1'b0;
  logic [1:0] level_sel = 2'd0;
  logic       ser_data;
  logic       ser_bclk;
  logic       ser_wclk;
  logic       latch_en;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sine_pattern_ser #(
    .W(W), .DEPTH(DEPTH), .AMPL(AMPL),
    .CLK_HZ(CLK_HZ), .SAMPLE_HZ(SRATE), .BITS_PER_SAMPLE(BPS)
  ) uut (
    .clk(clk), .rst(rst), .sample_tick(sample_tick), .level_sel(level_sel),
    .ser_data(ser_data), .ser_bclk(ser_bclk), .ser_wclk(ser_wclk), .latch_en(latch_en)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expected_word(input int idx, input int lvl);
    real s;
    int  raw;
    longint c;
    s   = real'(AMPL) * $sin(2.0 * 3.14159265358979 * real'(idx) / real'(DEPTH));
    raw = (s >= 0.0) ? $rtoi(s + 0.5) : $rtoi(s - 0.5);
    case (lvl)
      0:       c = 65536;
      1:       c = 6554;
      2:       c = 66;
      default: c = 0;
    endcase
    return int'((longint'(raw) * c + 32768) >>> 16);
  endfunction

  // Receiver model: shifts on rising bit clock, takes the word at the
  // first rising edge after the word clock falls.
  logic         prev_bclk = 1'b0;
  logic [W-1:0] rx_shift = '0;
  int           hi_edges = 0;
  bit           armed = 0;
  int           word_no = 0;
  int           latch_cnt = 0;
  int           wclk_high_seen = 0;
  int           cur_level = 0;

  always @(negedge clk) begin
    if (!rst) begin
      bit rise;
      rise = ser_bclk && !prev_bclk;
      if (latch_en) latch_cnt++;
      if (ser_wclk) wclk_high_seen++;
      if (rise) begin
        if (ser_wclk) begin
          rx_shift = {rx_shift[W-2:0], ser_data};
          hi_edges++;
          armed = 1;
        end else if (armed) begin
          int idx;
          int exp;
          string tag;
          idx = word_no % DEPTH;
          exp = expected_word(idx, cur_level);
          if (cur_level == 3) tag = "R7";
          else if (cur_level != 0) tag = "R6";
          else if (idx == 0 && word_no >= DEPTH) tag = "R3";
          else tag = "R2";
          check(int'($signed(rx_shift)) == exp, tag, int'($signed(rx_shift)), exp);
          check(hi_edges == W, "R4", hi_edges, W);
          check(latch_en == 1'b1, "R5", int'(latch_en), 1);
          word_no++;
          armed = 0;
          hi_edges = 0;
        end else begin
          check(latch_en == 1'b0, "R5", int'(latch_en), 0);
        end
      end else if (latch_en) begin
        check(1'b0, "R5", 1, 0);
      end
    end
    prev_bclk = ser_bclk;
  end

  task automatic send_tick();
    @(negedge clk);
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t_rise;
    int lc0;
    int wn0;
    repeat (5) @(negedge clk);
    // R1: outputs quiet under reset
    check({ser_data, ser_bclk, ser_wclk, latch_en} == 4'b0, "R1",
          int'({ser_data, ser_bclk, ser_wclk, latch_en}), 0);
    rst = 1'b0;
    @(negedge clk);
    check({ser_data, ser_bclk, ser_wclk, latch_en} == 4'b0, "R1",
          int'({ser_data, ser_bclk, ser_wclk, latch_en}), 0);

    // R9: bit clock period
    begin
      logic pb;
      int n;
      pb = ser_bclk;
      n = 0;
      while (!(ser_bclk && !pb)) begin pb = ser_bclk; @(negedge clk); end
      pb = ser_bclk;
      @(negedge clk);
      n = 1;
      while (!(ser_bclk && !pb)) begin pb = ser_bclk; @(negedge clk); n++; end
      t_rise = n;
    end
    check(t_rise == 2 * HALF_DIV, "R9", t_rise, 2 * HALF_DIV);

    // R10: idle without ticks
    repeat (300) @(negedge clk);
    check(latch_cnt == 0, "R10", latch_cnt, 0);
    check(wclk_high_seen == 0, "R10", wclk_high_seen, 0);

    // Sweep: two table periods per level code
    for (int lvl = 0; lvl < 4; lvl++) begin
      level_sel = 2'(lvl);
      cur_level = lvl;
      for (int k = 0; k < 2 * DEPTH; k++) begin
        send_tick();
        repeat (GAP) @(negedge clk);
      end
    end
    check(word_no == 8 * DEPTH, "R3", word_no, 8 * DEPTH);

    // R8: ticks while pending and while shifting are dropped
    level_sel = 2'd0;
    cur_level = 0;
    lc0 = latch_cnt;
    wn0 = word_no;
    send_tick();
    repeat (2) @(negedge clk);
    send_tick();
    repeat (30) @(negedge clk);
    send_tick();
    repeat (150) @(negedge clk);
    check(latch_cnt - lc0 == 1, "R8", latch_cnt - lc0, 1);
    check(word_no - wn0 == 1, "R8", word_no - wn0, 1);
    for (int k = 0; k < 3; k++) begin
      send_tick();
      repeat (GAP) @(negedge clk);
    end
    check(word_no - wn0 == 4, "R8", word_no - wn0, 4);

    finish_run();
  end

endmodule